// File: doc/BRIEF.md
# 100 Mb/s Link Qualification Monitor

This block turns the digital outputs of an analog peak detector into a debounced signal-detect flag and keeps the pass/fail link state of a 100 Mb/s physical layer. On copper, signal detect rises only after the high-energy flag has been true without a break for a programmable number of clock cycles (about 2 ms in a real system), and falls only after the low-energy flag has been true without a break for a shorter programmable time (about 1 ms). On fiber, an external optical receiver already performs the energy check, so its signal-detect input is passed straight through.

The link state machine begins in link-fail, where it asks the transmit path to send scrambled idle only. It moves to link-pass once signal detect and descrambler lock have both held for a qualification window, and falls back to link-fail on the next edge if either is lost. Local loopback forces the reported link status low and remote loopback forces it high, with local loopback winning when both are requested. All timers count system clock cycles and are parameters.

Top module: `link_qualifier`

## Requirements
- R1: On copper (fiber_sel low), sig_det rises after energy_hi has been sampled high on ASSERT_CYC consecutive rising clock edges, and not earlier.
- R2: Any single edge with energy_hi low while sig_det is low restarts the assert count from zero.
- R3: Once sig_det is high on copper, it falls after energy_lo has been sampled high on DEASSERT_CYC consecutive edges, and not earlier.
- R4: With fiber_sel high, sig_det equals fiber_sd in the same cycle, and energy_hi has no effect on it.
- R5: From link-fail, link_up rises after sig_det and descr_lock have both been high on QUAL_CYC consecutive edges, and not earlier.
- R6: In link-pass, one edge with sig_det low or descr_lock low returns the block to link-fail, and a new full QUAL_CYC window is then needed.
- R7: tx_idle_only is high exactly while the state machine is in link-fail, whatever the loopback inputs are.
- R8: While loop_local is high, link_up is low.
- R9: While loop_remote is high and loop_local is low, link_up is high.
- R10: After reset, sig_det (copper) and link_up are low and tx_idle_only is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| energy_hi | input | 1 | Peak detector above the assert threshold |
| energy_lo | input | 1 | Peak detector below the deassert threshold |
| fiber_sel | input | 1 | Fiber mode select |
| fiber_sd | input | 1 | Signal detect from the external optical receiver |
| loop_local | input | 1 | Local loopback active |
| loop_remote | input | 1 | Remote loopback active |
| descr_lock | input | 1 | Descrambler has locked |
| sig_det | output | 1 | Qualified signal detect |
| link_up | output | 1 | Link status after loopback overrides |
| tx_idle_only | output | 1 | Transmit path must send idle only |

## Verification
The bench builds the block with ASSERT_CYC=5, DEASSERT_CYC=3 and QUAL_CYC=4 instead of millisecond-scale counts. With windows this short, every pulse length from one cycle up to one past each threshold can be swept, so the exact edge at which sig_det and link_up change is checked on both sides of each limit, along with broken runs, requalification after a drop and every loopback combination in both link states.

// File: rtl/link_qualifier.sv
module link_qualifier #(
  parameter int ASSERT_CYC   = 250000,
  parameter int DEASSERT_CYC = 125000,
  parameter int QUAL_CYC     = 62500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic energy_hi,
  input  logic energy_lo,
  input  logic fiber_sel,
  input  logic fiber_sd,
  input  logic loop_local,
  input  logic loop_remote,
  input  logic descr_lock,
  output logic sig_det,
  output logic link_up,
  output logic tx_idle_only
);

  localparam int DMAX = (ASSERT_CYC > DEASSERT_CYC) ? ASSERT_CYC : DEASSERT_CYC;
  localparam int DW   = $clog2(DMAX + 1);
  localparam int QW   = $clog2(QUAL_CYC + 1);
  localparam logic [DW-1:0] A_LAST = DW'(ASSERT_CYC - 1);
  localparam logic [DW-1:0] D_LAST = DW'(DEASSERT_CYC - 1);
  localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYC - 1);

  logic          sd_cu;
  logic [DW-1:0] dcnt;
  logic          pass;
  logic [QW-1:0] qcnt;
  logic          good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_cu <= 1'b0;
      dcnt  <= '0;
    end else if (!sd_cu) begin
      if (!energy_hi) dcnt <= '0;
      else if (dcnt == A_LAST) begin
        sd_cu <= 1'b1;
        dcnt  <= '0;
      end else dcnt <= dcnt + 1'b1;
    end else begin
      if (!energy_lo) dcnt <= '0;
      else if (dcnt == D_LAST) begin
        sd_cu <= 1'b0;
        dcnt  <= '0;
      end else dcnt <= dcnt + 1'b1;
    end
  end

  assign sig_det = fiber_sel ? fiber_sd : sd_cu;
  assign good    = sig_det & descr_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass <= 1'b0;
      qcnt <= '0;
    end else if (!pass) begin
      if (!good) qcnt <= '0;
      else if (qcnt == Q_LAST) begin
        pass <= 1'b1;
        qcnt <= '0;
      end else qcnt <= qcnt + 1'b1;
    end else if (!good) begin
      pass <= 1'b0;
      qcnt <= '0;
    end
  end

  assign link_up      = loop_local ? 1'b0 : (loop_remote | pass);
  assign tx_idle_only = ~pass;

  a_r1_rise_needs_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_cu) |-> $past(energy_hi));

  a_r3_fall_needs_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_cu) |-> $past(energy_lo));

  a_r5_pass_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(sig_det && descr_lock));

  a_r6_drop_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && !(sig_det && descr_lock)) |=> !pass);

  a_r5_qual_bound: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt <= Q_LAST);

endmodule

// File: tb/test_link_qualifier.sv
module test_link_qualifier;
  localparam int A = 5;
  localparam int D = 3;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic energy_hi = 0, energy_lo = 0, fiber_sel = 0, fiber_sd = 0;
  logic loop_local = 0, loop_remote = 0, descr_lock = 0;
  logic sig_det, link_up, tx_idle_only;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  link_qualifier #(.ASSERT_CYC(A), .DEASSERT_CYC(D), .QUAL_CYC(Q)) i_link_qualifier (
    .clk(clk), .rst_n(rst_n), .energy_hi(energy_hi), .energy_lo(energy_lo),
    .fiber_sel(fiber_sel), .fiber_sd(fiber_sd), .loop_local(loop_local),
    .loop_remote(loop_remote), .descr_lock(descr_lock), .sig_det(sig_det),
    .link_up(link_up), .tx_idle_only(tx_idle_only));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    energy_hi = 0; energy_lo = 0; fiber_sel = 0; fiber_sd = 0;
    loop_local = 0; loop_remote = 0; descr_lock = 0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(1);
    do_reset();
    chk("R10 sig_det", sig_det, 1'b0);
    chk("R10 link_up", link_up, 1'b0);
    chk("R10 tx_idle_only", tx_idle_only, 1'b1);

    for (int n = 1; n <= A + 1; n++) begin
      do_reset();
      energy_hi = 1;
      step(n);
      chk("R1 assert sweep", sig_det, n >= A);
    end

    do_reset();
    energy_hi = 1; step(A - 1);
    energy_hi = 0; step(1);
    chk("R2 gap", sig_det, 1'b0);
    energy_hi = 1; step(A - 1);
    chk("R2 restart short", sig_det, 1'b0);
    step(1);
    chk("R2 restart full", sig_det, 1'b1);

    for (int m = 1; m <= D + 1; m++) begin
      do_reset();
      energy_hi = 1; step(A);
      energy_hi = 0; energy_lo = 1;
      step(m);
      chk("R3 deassert sweep", sig_det, m < D);
    end

    do_reset();
    fiber_sel = 1; fiber_sd = 0; energy_hi = 1;
    step(A + 2);
    chk("R4 energy ignored", sig_det, 1'b0);
    fiber_sd = 1; #1;
    chk("R4 follow high", sig_det, 1'b1);
    fiber_sd = 0; #1;
    chk("R4 follow low", sig_det, 1'b0);

    for (int n = 1; n <= Q + 1; n++) begin
      do_reset();
      fiber_sel = 1; fiber_sd = 1; descr_lock = 1;
      step(n);
      chk("R5 qual sweep", link_up, n >= Q);
      chk("R7 idle sweep", tx_idle_only, n < Q);
    end

    do_reset();
    fiber_sel = 1; fiber_sd = 1; descr_lock = 1;
    step(Q - 1);
    descr_lock = 0; step(1);
    descr_lock = 1; step(Q - 1);
    chk("R5 broken window", link_up, 1'b0);
    step(1);
    chk("R5 full window", link_up, 1'b1);

    descr_lock = 0; step(1);
    chk("R6 lock loss", link_up, 1'b0);
    chk("R7 idle on fail", tx_idle_only, 1'b1);
    descr_lock = 1; step(Q - 1);
    chk("R6 requal short", link_up, 1'b0);
    step(1);
    chk("R6 requal full", link_up, 1'b1);
    fiber_sd = 0; step(1);
    chk("R6 signal loss", link_up, 1'b0);

    do_reset();
    loop_remote = 1; #1;
    chk("R9 remote in fail", link_up, 1'b1);
    chk("R7 remote in fail", tx_idle_only, 1'b1);
    loop_local = 1; #1;
    chk("R9 local wins", link_up, 1'b0);
    loop_remote = 0; loop_local = 0;
    fiber_sel = 1; fiber_sd = 1; descr_lock = 1;
    step(Q);
    chk("R5 pass before loop", link_up, 1'b1);
    loop_local = 1; #1;
    chk("R8 local in pass", link_up, 1'b0);
    chk("R7 local in pass", tx_idle_only, 1'b0);
    step(2);
    chk("R8 local held", link_up, 1'b0);
    loop_local = 0; #1;
    chk("R8 release", link_up, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule